// File: doc/BRIEF.md
# In-Order Completion Queue with Precise Exceptions

This block tracks instructions between in-order dispatch and in-order retirement in a core whose execution units may finish work out of order. Each dispatched instruction takes the next slot of a six-entry circular queue. Execution units report back by slot index, each report marked either clean or excepting with a cause code. The queue retires the oldest entry once it has finished cleanly.

When the oldest entry is found finished with an exception, the block takes that exception. It drives a one-cycle save strobe with the faulting instruction address and a handler vector derived from the cause. In the same cycle it discards that entry and every younger one. Because an exception is only taken at the head, an older fault always wins over a younger one. The block also grants permission to a store buffer: one grant per cycle, for the oldest store that may now write memory.

The queue mixes two capacity limits. All six slots may hold condition-code or branch instructions, but integer-class instructions may occupy at most four of them. Dispatch stalls when the incoming instruction's class has no room.

Top module: `cmpl_queue`

## Requirements
- R1: After reset the queue is empty. `disp_ready` is high, `disp_idx` is 0, and `ret_valid`, `exc_take` and `st_release` are low.
- R2: Accepted dispatches (`disp_valid` and `disp_ready` high at a clock edge) take slots in ascending order from 0 to 5 and then wrap to 0. `disp_idx` shows the slot that the next accepted instruction will take.
- R3: `disp_ready` is low for an integer instruction (`disp_int`=1) while four integer entries are occupied. A non-integer instruction can still be accepted if a slot is free.
- R4: `disp_ready` is low while all six slots are occupied. Occupancy never exceeds six.
- R5: A completion on either port marks the slot done and records its exception flag and cause. A completion that names an empty slot, a slot index of 6 or more, or a slot that is already done has no effect. If both ports name the same slot in one cycle, port 1's values are kept.
- R6: `ret_valid` is high, with `ret_pc` equal to the head instruction's address, exactly when the head entry is done without exception. One entry retires per cycle, in program order.
- R7: `exc_take` is high exactly when the head entry is done with an exception, and `exc_pc` is then that entry's address. Older entries retire normally before it.
- R8: An exception reported by a younger entry is not taken while any older entry is pending. If an older entry faults later, the older exception is taken and the younger one is discarded.
- R9: In the cycle `exc_take` is high, all entries are flushed. `disp_ready` is low in that cycle and in the next one. The queue is then empty and dispatch restarts at slot 0.
- R10: `exc_vector` = `vec_base` + offset, where the offset depends on the 3-bit cause. Cause 4 (instruction breakpoint) gives 0x1D00; cause 5 (data breakpoint) gives 0x1C00; cause 6 (maskable debug request or peripheral breakpoint) gives 0x1E00; cause 7 (non-maskable debug request) gives 0x1F00. Causes 0 to 3 give 0x0300 + cause×0x100.
- R11: `st_release` pulses once per store, with `st_release_idx` naming its slot. The store must be done without exception, and every older entry must be done without exception; a store at the head needs only itself done. When several stores qualify, the oldest is released first, one per cycle.
- R12: `exc_take` lasts a single cycle per taken exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_base | input | 32 | Base address of the handler vectors |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_int | input | 1 | Offered instruction is integer class |
| disp_store | input | 1 | Offered instruction is a store |
| disp_pc | input | 32 | Offered instruction address |
| disp_ready | output | 1 | Offered instruction is accepted at this edge |
| disp_idx | output | 3 | Slot the next accepted instruction takes |
| c0_valid | input | 1 | Completion port 0 valid |
| c0_idx | input | 3 | Completion port 0 slot |
| c0_exc | input | 1 | Completion port 0 exception flag |
| c0_cause | input | 3 | Completion port 0 cause code |
| c1_valid | input | 1 | Completion port 1 valid |
| c1_idx | input | 3 | Completion port 1 slot |
| c1_exc | input | 1 | Completion port 1 exception flag |
| c1_cause | input | 3 | Completion port 1 cause code |
| ret_valid | output | 1 | Head entry retires this cycle |
| ret_pc | output | 32 | Address of the retiring entry |
| exc_take | output | 1 | Exception taken and queue flushed this cycle |
| exc_pc | output | 32 | Save/restore address (faulting instruction) |
| exc_vector | output | 32 | Handler address |
| st_release | output | 1 | A store may commit to memory |
| st_release_idx | output | 3 | Slot of the released store |

## Verification
The hardest case to reach is an older fault arriving after a younger entry has already reported its own exception. The older fault must then win, and the younger one must vanish in the flush. Random completion order seldom produces this ordering. A directed sequence therefore dispatches three entries, faults the youngest, then faults the middle one, and only then finishes the oldest. It then follows the retire, the take, the hold cycle and the restart at slot 0. Long random runs with both completion ports active mix stores, integer caps and rare exceptions against a cycle-accurate bench model. That model is what covers store grants behind slow older entries.

// File: rtl/cmpl_queue.sv
module cmpl_queue #(
  parameter int DEPTH   = 6,
  parameter int INT_MAX = 4,
  parameter int AW      = 32,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] vec_base,
  input  logic          disp_valid,
  input  logic          disp_int,
  input  logic          disp_store,
  input  logic [AW-1:0] disp_pc,
  output logic          disp_ready,
  output logic [$clog2(DEPTH)-1:0] disp_idx,
  input  logic          c0_valid,
  input  logic [$clog2(DEPTH)-1:0] c0_idx,
  input  logic          c0_exc,
  input  logic [CW-1:0] c0_cause,
  input  logic          c1_valid,
  input  logic [$clog2(DEPTH)-1:0] c1_idx,
  input  logic          c1_exc,
  input  logic [CW-1:0] c1_cause,
  output logic          ret_valid,
  output logic [AW-1:0] ret_pc,
  output logic          exc_take,
  output logic [AW-1:0] exc_pc,
  output logic [AW-1:0] exc_vector,
  output logic          st_release,
  output logic [$clog2(DEPTH)-1:0] st_release_idx
);
  localparam int IW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld, isint, isst, done, exc, rel;
  logic [CW-1:0]    cause [DEPTH];
  logic [AW-1:0]    pc    [DEPTH];
  logic [IW-1:0]    head, tail;
  logic [CNTW-1:0]  cnt, icnt;
  logic             hold, fire, clean;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [15:0] voff(input logic [CW-1:0] c);
    case (c)
      CW'(4):  return 16'h1D00;
      CW'(5):  return 16'h1C00;
      CW'(6):  return 16'h1E00;
      CW'(7):  return 16'h1F00;
      default: return 16'h0300 + {6'd0, c[1:0], 8'd0};
    endcase
  endfunction

  assign exc_take   = vld[head] & done[head] & exc[head];
  assign ret_valid  = vld[head] & done[head] & ~exc[head];
  assign ret_pc     = pc[head];
  assign exc_pc     = pc[head];
  assign exc_vector = vec_base + AW'(voff(cause[head]));
  assign disp_idx   = tail;
  assign disp_ready = ~hold & ~exc_take & (cnt < CNTW'(DEPTH))
                    & (~disp_int | (icnt < CNTW'(INT_MAX)));
  assign fire       = disp_valid & disp_ready;

  always_comb begin
    st_release     = 1'b0;
    st_release_idx = '0;
    clean          = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = int'(head) + k;
      if (s >= DEPTH) s = s - DEPTH;
      if (k < int'(cnt)) begin
        if (!st_release && clean && isst[s] && done[s] && !exc[s] && !rel[s]) begin
          st_release     = 1'b1;
          st_release_idx = IW'(s);
        end
        clean = clean & done[s] & ~exc[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0; isint <= '0; isst <= '0; done <= '0; exc <= '0; rel <= '0;
      head <= '0; tail <= '0; cnt <= '0; icnt <= '0; hold <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        cause[i] <= '0;
        pc[i]    <= '0;
      end
    end else if (exc_take) begin
      vld  <= '0;
      head <= '0; tail <= '0; cnt <= '0; icnt <= '0;
      hold <= 1'b1;
    end else begin
      hold <= 1'b0;
      if (c0_valid && int'(c0_idx) < DEPTH && vld[c0_idx] && !done[c0_idx]) begin
        done[c0_idx]  <= 1'b1;
        exc[c0_idx]   <= c0_exc;
        cause[c0_idx] <= c0_cause;
      end
      if (c1_valid && int'(c1_idx) < DEPTH && vld[c1_idx] && !done[c1_idx]) begin
        done[c1_idx]  <= 1'b1;
        exc[c1_idx]   <= c1_exc;
        cause[c1_idx] <= c1_cause;
      end
      if (st_release) rel[st_release_idx] <= 1'b1;
      if (ret_valid) begin
        vld[head] <= 1'b0;
        head      <= nxt(head);
      end
      if (fire) begin
        vld[tail]   <= 1'b1;
        isint[tail] <= disp_int;
        isst[tail]  <= disp_store;
        done[tail]  <= 1'b0;
        exc[tail]   <= 1'b0;
        rel[tail]   <= 1'b0;
        pc[tail]    <= disp_pc;
        tail        <= nxt(tail);
      end
      cnt  <= cnt + CNTW'(fire) - CNTW'(ret_valid);
      icnt <= icnt + CNTW'(fire & disp_int) - CNTW'(ret_valid & isint[head]);
    end
  end
endmodule

// File: rtl/cmpl_queue_chk.sv
module cmpl_queue_chk #(
  parameter int DEPTH   = 6,
  parameter int INT_MAX = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       disp_int,
  input logic                       disp_ready,
  input logic                       ret_valid,
  input logic                       exc_take,
  input logic [$clog2(DEPTH+1)-1:0] cnt,
  input logic [$clog2(DEPTH+1)-1:0] icnt
);
  localparam int CNTW = $clog2(DEPTH + 1);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(DEPTH));
  a_r3_int_cap: assert property (@(posedge clk) disable iff (!rst_n)
    icnt <= CNTW'(INT_MAX));
  a_r3_int_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (icnt == CNTW'(INT_MAX) && disp_int) |-> !disp_ready);
  a_r6_no_retire_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_valid && exc_take));
  a_r9_hold_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !disp_ready);
  a_r9_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (cnt == '0));
  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !exc_take);
endmodule

bind cmpl_queue cmpl_queue_chk #(.DEPTH(DEPTH), .INT_MAX(INT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_int(disp_int), .disp_ready(disp_ready),
  .ret_valid(ret_valid), .exc_take(exc_take), .cnt(cnt), .icnt(icnt)
);

// File: tb/tb_cmpl_queue.sv
`timescale 1ns/1ps
module tb_cmpl_queue;
  localparam int D = 6;

  logic clk = 0, rst_n = 0;
  logic [31:0] vec_base;
  logic disp_valid, disp_int, disp_store;
  logic [31:0] disp_pc;
  logic disp_ready;
  logic [2:0] disp_idx;
  logic c0_valid, c0_exc, c1_valid, c1_exc;
  logic [2:0] c0_idx, c0_cause, c1_idx, c1_cause;
  logic ret_valid, exc_take, st_release;
  logic [31:0] ret_pc, exc_pc, exc_vector;
  logic [2:0] st_release_idx;

  cmpl_queue dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit fin = 0;

  bit m_v[D], m_int[D], m_st[D], m_done[D], m_exc[D], m_rel[D];
  int m_cause[D];
  logic [31:0] m_pc[D];
  int m_head, m_tail, m_cnt, m_icnt;
  bit m_hold;

  bit o_rdy, o_ret, o_take, o_rel;
  logic [31:0] o_retpc, o_excpc, o_vec;
  int o_idx, o_relidx;

  function automatic logic [31:0] exp_vec(input logic [31:0] b, input int c);
    case (c)
      4: return b + 32'h1D00;
      5: return b + 32'h1C00;
      6: return b + 32'h1E00;
      7: return b + 32'h1F00;
      default: return b + 32'h0300 + 32'(c) * 32'h100;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_int = 0; disp_store = 0; disp_pc = 0;
    c0_valid = 0; c0_idx = 0; c0_exc = 0; c0_cause = 0;
    c1_valid = 0; c1_idx = 0; c1_exc = 0; c1_cause = 0;
  endtask

  task automatic mreset();
    for (int i = 0; i < D; i++) begin
      m_v[i] = 0; m_int[i] = 0; m_st[i] = 0; m_done[i] = 0;
      m_exc[i] = 0; m_rel[i] = 0; m_cause[i] = 0; m_pc[i] = 0;
    end
    m_head = 0; m_tail = 0; m_cnt = 0; m_icnt = 0; m_hold = 0;
  endtask

  task automatic cyc();
    bit et, er, erdy, erel, clean, ok0, ok1;
    int ri;
    string rtag;
    #1;
    et = m_v[m_head] && m_done[m_head] && m_exc[m_head];
    er = m_v[m_head] && m_done[m_head] && !m_exc[m_head];
    erdy = !m_hold && !et && m_cnt < D && (!disp_int || m_icnt < 4);
    erel = 0; ri = 0; clean = 1;
    for (int k = 0; k < m_cnt; k++) begin
      int s = (m_head + k) % D;
      if (!erel && clean && m_st[s] && m_done[s] && !m_exc[s] && !m_rel[s]) begin
        erel = 1; ri = s;
      end
      clean = clean && m_done[s] && !m_exc[s];
    end
    o_rdy = disp_ready; o_ret = ret_valid; o_take = exc_take; o_rel = st_release;
    o_retpc = ret_pc; o_excpc = exc_pc; o_vec = exc_vector;
    o_idx = int'(disp_idx); o_relidx = int'(st_release_idx);
    if (m_hold || et) rtag = "R9";
    else if (m_cnt >= D) rtag = "R4";
    else if (disp_int && m_icnt >= 4) rtag = "R3";
    else rtag = "R4";
    chk(o_rdy == erdy, rtag, "disp_ready", o_rdy, erdy);
    chk(o_idx == m_tail, "R2", "disp_idx", o_idx, m_tail);
    chk(o_ret == er, "R6", "ret_valid", o_ret, er);
    if (er) chk(o_retpc == m_pc[m_head], "R6", "ret_pc", o_retpc, m_pc[m_head]);
    chk(o_take == et, "R7", "exc_take", o_take, et);
    if (et) begin
      chk(o_excpc == m_pc[m_head], "R7", "exc_pc", o_excpc, m_pc[m_head]);
      chk(o_vec == exp_vec(vec_base, m_cause[m_head]), "R10", "exc_vector",
          o_vec, exp_vec(vec_base, m_cause[m_head]));
    end
    chk(o_rel == erel, "R11", "st_release", o_rel, erel);
    if (erel) chk(o_relidx == ri, "R11", "st_release_idx", o_relidx, ri);
    if (et) begin
      for (int i = 0; i < D; i++) m_v[i] = 0;
      m_head = 0; m_tail = 0; m_cnt = 0; m_icnt = 0; m_hold = 1;
    end else begin
      m_hold = 0;
      ok0 = c0_valid && c0_idx < D && m_v[c0_idx] && !m_done[c0_idx];
      ok1 = c1_valid && c1_idx < D && m_v[c1_idx] && !m_done[c1_idx];
      if (ok0) begin m_done[c0_idx] = 1; m_exc[c0_idx] = c0_exc; m_cause[c0_idx] = c0_cause; end
      if (ok1) begin m_done[c1_idx] = 1; m_exc[c1_idx] = c1_exc; m_cause[c1_idx] = c1_cause; end
      if (erel) m_rel[ri] = 1;
      if (er) begin
        m_v[m_head] = 0;
        if (m_int[m_head]) m_icnt--;
        m_head = (m_head + 1) % D; m_cnt--;
      end
      if (disp_valid && erdy) begin
        m_v[m_tail] = 1; m_int[m_tail] = disp_int; m_st[m_tail] = disp_store;
        m_done[m_tail] = 0; m_exc[m_tail] = 0; m_rel[m_tail] = 0;
        m_pc[m_tail] = disp_pc;
        if (disp_int) m_icnt++;
        m_tail = (m_tail + 1) % D; m_cnt++;
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic disp(input bit isint, input bit st, input logic [31:0] pc);
    disp_valid = 1; disp_int = isint; disp_store = st; disp_pc = pc;
  endtask

  task automatic drain();
    for (int n = 0; n < 60 && (m_cnt != 0 || m_hold); n++) begin
      for (int k = 0; k < m_cnt; k++) begin
        int s = (m_head + k) % D;
        if (!m_done[s] && !c0_valid) begin c0_valid = 1; c0_idx = 3'(s); end
      end
      cyc();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    void'($urandom(32'h5EED1234));
    vec_base = 32'h0004_0000;
    idle();
    mreset();
    repeat (4) @(negedge clk);
    rst_n = 1;

    disp_int = 1;
    cyc();
    chk(o_rdy == 1 && o_idx == 0, "R1", "ready/idx after reset", {o_rdy, 3'(o_idx)}, 4'b1000);
    chk(!o_ret && !o_take && !o_rel, "R1", "strobes after reset", {o_ret, o_take, o_rel}, 0);

    for (int i = 0; i < 4; i++) begin disp(1, 0, 32'h100 + 4 * i); cyc(); end
    disp(1, 0, 32'h110); cyc();
    chk(o_rdy == 0, "R3", "fifth integer stalls", o_rdy, 0);
    disp(0, 0, 32'h114); cyc();
    chk(o_rdy == 1 && o_idx == 4, "R2", "non-integer accepted at slot 4", o_idx, 4);
    disp(0, 0, 32'h118); cyc();
    disp(0, 0, 32'h11C); cyc();
    chk(o_rdy == 0, "R4", "full queue stalls", o_rdy, 0);
    drain();

    drain();
    t = m_tail;
    c0_valid = 1; c0_idx = 3'(t); c0_exc = 1; cyc();
    disp(1, 0, 32'h200); cyc();
    disp(1, 0, 32'h204); cyc();
    chk(o_ret == 0, "R5", "completion to empty slot ignored", o_ret, 0);
    c0_valid = 1; c0_idx = 3'((t + 1) % D); cyc();
    c1_valid = 1; c1_idx = 3'((t + 1) % D); c1_exc = 1; c1_cause = 7; cyc();
    c0_valid = 1; c0_idx = 3'(t); cyc();
    cyc();
    chk(o_ret == 1 && o_retpc == 32'h200, "R5", "first entry retires", o_retpc, 32'h200);
    cyc();
    chk(o_ret == 1 && o_take == 0, "R5", "second completion to done slot ignored", o_take, 0);
    drain();

    drain();
    t = m_tail;
    disp(1, 0, 32'h300); cyc();
    disp(0, 1, 32'h304); cyc();
    c0_valid = 1; c0_idx = 3'((t + 1) % D); cyc();
    c0_valid = 1; c0_idx = 3'(t); cyc();
    chk(o_rel == 0, "R11", "store waits on older entry", o_rel, 0);
    cyc();
    chk(o_rel == 1 && o_relidx == (t + 1) % D, "R11", "store released", o_relidx, (t + 1) % D);
    cyc();
    chk(o_rel == 0, "R11", "single release per store", o_rel, 0);
    drain();

    drain();
    disp(1, 0, 32'h400); cyc();
    disp(1, 0, 32'h404); cyc();
    disp(0, 0, 32'h408); cyc();
    t = m_head;
    c0_valid = 1; c0_idx = 3'((t + 2) % D); c0_exc = 1; c0_cause = 5; cyc();
    c1_valid = 1; c1_idx = 3'((t + 1) % D); c1_exc = 1; c1_cause = 4; cyc();
    chk(o_take == 0, "R8", "younger fault not taken early", o_take, 0);
    c0_valid = 1; c0_idx = 3'(t); cyc();
    cyc();
    chk(o_ret == 1 && o_retpc == 32'h400 && o_take == 0, "R7", "older entry retires first", o_retpc, 32'h400);
    disp(1, 0, 32'h500); cyc();
    chk(o_take == 1 && o_excpc == 32'h404, "R8", "older fault taken", o_excpc, 32'h404);
    chk(o_vec == vec_base + 32'h1D00, "R10", "instruction breakpoint vector", o_vec, vec_base + 32'h1D00);
    chk(o_rdy == 0, "R9", "no dispatch in flush cycle", o_rdy, 0);
    disp(1, 0, 32'h500); cyc();
    chk(o_take == 0, "R12", "strobe lasts one cycle", o_take, 0);
    chk(o_rdy == 0 && o_ret == 0, "R9", "hold cycle after flush", o_rdy, 0);
    disp(1, 0, 32'h500); cyc();
    chk(o_rdy == 1 && o_idx == 0, "R9", "restart at slot 0", o_idx, 0);
    drain();

    for (int c = 0; c < 8; c++) begin
      drain();
      t = m_tail;
      disp(c[0], 0, 32'h600 + 4 * c); cyc();
      c0_valid = 1; c0_idx = 3'(t); c0_exc = 1; c0_cause = 3'(c); cyc();
      cyc();
      chk(o_take == 1 && o_vec == exp_vec(vec_base, c), "R10", "vector by cause", o_vec, exp_vec(vec_base, c));
    end
    drain();

    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 9) < 7)
        disp($urandom_range(0, 9) < 6, $urandom_range(0, 9) < 3, {$urandom_range(0, 32'hFFFF), 2'b00});
      if ($urandom_range(0, 9) < 6) begin
        c0_valid = 1; c0_idx = 3'($urandom_range(0, 7));
        c0_exc = $urandom_range(0, 39) == 0; c0_cause = 3'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 9) < 4) begin
        c1_valid = 1; c1_idx = 3'($urandom_range(0, 7));
        c1_exc = $urandom_range(0, 39) == 0; c1_cause = 3'($urandom_range(0, 7));
      end
      cyc();
    end
    drain();

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule